// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the control-state update that happens at the moment a processor takes an exception. For each exception request it receives a 5-bit cause code, a refill flag, the faulting PC and a flag that says whether the faulting instruction sits in a branch delay slot. From these it loads the cause code and the delay-slot flag, and it updates the saved exception PC. It also tells the Status logic to raise its exception-level bit. Finally it produces the PC and next-PC that the fetch unit must jump to.

The Status bits that control the sequence come in as plain inputs. These are the bootstrap-vector select, the exception-level and error-level bits, and the three extended-addressing enables for user, supervisor and kernel space. A 2-bit region field gives the address space of the faulting access. The block has no Status register of its own. When the exception-level bit has to be raised, it emits a one-cycle strobe, and the Status owner acts on it. All outputs are registered. A one-cycle taken pulse marks the cycle in which the redirect is valid. The redirect target stays on its outputs until the next accepted exception replaces it.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is high and after it is released with no request, every output is 0: taken, redirect_pc, redirect_npc, exl_set, epc, cause_code and cause_bd.
- R2: A request made while sr_erl is 1 is ignored. In the following cycle taken and exl_set are 0, and epc, cause_code, cause_bd, redirect_pc and redirect_npc keep their values.
- R3: A request with sr_erl at 0 is accepted. In the cycle after it, taken is 1 for exactly one cycle and cause_code equals the request's exc_code. Without a request, taken is 0.
- R4: On an accepted request, cause_bd takes the value of exc_in_delay. The exception PC candidate is exc_pc minus 4 when exc_in_delay is 1, and exc_pc otherwise.
- R5: On an accepted request with sr_exl at 0, epc is loaded with the candidate and exl_set pulses for one cycle. With sr_exl at 1, epc is kept and exl_set stays 0, but cause_code and cause_bd are still updated.
- R6: The vector base is 0x8000_0000 when sr_bev is 0 and 0xBFC0_0200 when sr_bev is 1. A non-refill exception (exc_refill 0) redirects to base + 0x180.
- R7: A refill exception that does not use extended addressing redirects to the base itself.
- R8: A refill redirects to base + 0x080 when fault_region is 0 with sr_ux set, 1 with sr_sx set, or 3 with sr_kx set. Region 2 never selects the extended offset.
- R9: On every accepted request, redirect_npc equals redirect_pc + 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception request, one cycle per exception |
| exc_code | input | 5 | Cause code of the exception |
| exc_refill | input | 1 | Request is a translation refill |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| sr_bev | input | 1 | Status bootstrap-vector select |
| sr_exl | input | 1 | Status exception level |
| sr_erl | input | 1 | Status error level |
| sr_ux | input | 1 | Extended addressing enabled for user space |
| sr_sx | input | 1 | Extended addressing enabled for supervisor space |
| sr_kx | input | 1 | Extended addressing enabled for kernel space |
| fault_region | input | 2 | Region of the faulting address (0 user, 1 supervisor, 3 kernel) |
| taken | output | 1 | One-cycle pulse: redirect is valid |
| redirect_pc | output | 32 | New PC at the exception vector |
| redirect_npc | output | 32 | New next-PC (redirect_pc + 4) |
| exl_set | output | 1 | One-cycle strobe to raise Status exception level |
| epc | output | 32 | Saved exception PC |
| cause_code | output | 5 | Cause exception code field |
| cause_bd | output | 1 | Cause branch-delay flag |

## Verification
The main function is tried with first-level and nested requests, each both in and out of a delay slot. These cases separate EPC capture from the Cause update, which always happens. Refill requests go through every region, with the matching enable on, with it off, and with a mismatched enable set. This shows that only the region's own enable selects the extended offset, and that region 2 never does. Each vector case runs with both bootstrap-select values, which separates the base choice from the offset choice. An error-level request shows that the block leaves all of its state untouched.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN_D   = 32;
    localparam int CODE_W_D = 5;
    localparam int REGION_W = 2;

    typedef enum logic [REGION_W-1:0] {
        RGN_USER   = 2'd0,
        RGN_SUPER  = 2'd1,
        RGN_RSVD   = 2'd2,
        RGN_KERNEL = 2'd3
    } region_e;

    typedef struct packed {
        logic          in_delay;
        logic [31:0]   pc;
    } fault_t;

    // Extended refill is chosen only by the enable of the faulting region
    function automatic logic wants_xrefill(region_e rgn, logic ux, logic sx, logic kx);
        case (rgn)
            RGN_USER:   return ux;
            RGN_SUPER:  return sx;
            RGN_KERNEL: return kx;
            default:    return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel #(
    parameter int          XLEN       = 32,
    parameter logic [31:0] BASE_NORM  = 32'h8000_0000,
    parameter logic [31:0] BASE_BOOT  = 32'hBFC0_0200,
    parameter logic [31:0] OFF_GEN    = 32'h0000_0180,
    parameter logic [31:0] OFF_XREF   = 32'h0000_0080,
    parameter int          INST_BYTES = 4
) (
    input  logic            bev,
    input  logic            refill,
    input  logic            xrefill,
    output logic [XLEN-1:0] vec_pc,
    output logic [XLEN-1:0] vec_npc
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        base = bev ? XLEN'(BASE_BOOT) : XLEN'(BASE_NORM);
        if (!refill)
            offset = XLEN'(OFF_GEN);
        else if (xrefill)
            offset = XLEN'(OFF_XREF);
        else
            offset = '0;
        vec_pc  = base + offset;
        vec_npc = base + offset + XLEN'(INST_BYTES);
    end
endmodule

// File: rtl/exc_epc_sel.sv
module exc_epc_sel #(
    parameter int XLEN       = 32,
    parameter int INST_BYTES = 4
) (
    input  logic [XLEN-1:0] pc,
    input  logic            in_delay,
    output logic [XLEN-1:0] epc_cand,
    output logic            bd
);
    always_comb begin
        bd       = in_delay;
        epc_cand = in_delay ? (pc - XLEN'(INST_BYTES)) : pc;
    end
endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              exl_now,
    input  logic [CODE_W-1:0] code_in,
    input  logic              bd_in,
    input  logic [XLEN-1:0]   epc_in,
    output logic [XLEN-1:0]   epc_q,
    output logic [CODE_W-1:0] code_q,
    output logic              bd_q,
    output logic              exl_set_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q     <= '0;
            code_q    <= '0;
            bd_q      <= 1'b0;
            exl_set_q <= 1'b0;
        end else begin
            exl_set_q <= accept && !exl_now;
            if (accept) begin
                code_q <= code_in;
                bd_q   <= bd_in;
                if (!exl_now)
                    epc_q <= epc_in;
            end
        end
    end

    // R5: nested exception keeps the saved PC and raises no strobe
    assert_nested_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && exl_now) |=> ($stable(epc_q) && !exl_set_q));

    // R5: first-level exception captures the candidate
    assert_first_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && !exl_now) |=> (epc_q == $past(epc_in) && exl_set_q));

    // R3: accepted code lands in the cause field
    assert_code_load_R3: assert property (@(posedge clk) disable iff (rst)
        accept |=> (code_q == $past(code_in) && bd_q == $past(bd_in)));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int XLEN       = XLEN_D,
    parameter int CODE_W     = CODE_W_D,
    parameter int INST_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              exc_refill,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic              exc_in_delay,
    input  logic              sr_bev,
    input  logic              sr_exl,
    input  logic              sr_erl,
    input  logic              sr_ux,
    input  logic              sr_sx,
    input  logic              sr_kx,
    input  logic [1:0]        fault_region,
    output logic              taken,
    output logic [XLEN-1:0]   redirect_pc,
    output logic [XLEN-1:0]   redirect_npc,
    output logic              exl_set,
    output logic [XLEN-1:0]   epc,
    output logic [CODE_W-1:0] cause_code,
    output logic              cause_bd
);
    logic            accept;
    logic            use_xref;
    logic [XLEN-1:0] vec_pc;
    logic [XLEN-1:0] vec_npc;
    logic [XLEN-1:0] epc_cand;
    logic            bd_cand;

    assign accept   = exc_req && !sr_erl;
    assign use_xref = wants_xrefill(region_e'(fault_region), sr_ux, sr_sx, sr_kx);

    exc_vec_sel #(.XLEN(XLEN), .INST_BYTES(INST_BYTES)) u_vec (
        .bev     (sr_bev),
        .refill  (exc_refill),
        .xrefill (use_xref),
        .vec_pc  (vec_pc),
        .vec_npc (vec_npc)
    );

    exc_epc_sel #(.XLEN(XLEN), .INST_BYTES(INST_BYTES)) u_epc (
        .pc       (exc_pc),
        .in_delay (exc_in_delay),
        .epc_cand (epc_cand),
        .bd       (bd_cand)
    );

    exc_ctrl_regs #(.XLEN(XLEN), .CODE_W(CODE_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .exl_now   (sr_exl),
        .code_in   (exc_code),
        .bd_in     (bd_cand),
        .epc_in    (epc_cand),
        .epc_q     (epc),
        .code_q    (cause_code),
        .bd_q      (cause_bd),
        .exl_set_q (exl_set)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            taken        <= 1'b0;
            redirect_pc  <= '0;
            redirect_npc <= '0;
        end else begin
            taken <= accept;
            if (accept) begin
                redirect_pc  <= vec_pc;
                redirect_npc <= vec_npc;
            end
        end
    end

    // R2: error level blocks every state change
    assert_erl_ignore_R2: assert property (@(posedge clk) disable iff (rst)
        (exc_req && sr_erl) |=> (!taken && !exl_set && $stable(epc)
                                 && $stable(cause_code) && $stable(redirect_pc)));

    // R3: taken follows only accepted requests
    assert_taken_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        !(exc_req && !sr_erl) |=> !taken);

    // R9: next-PC is one instruction past the vector
    assert_npc_step_R9: assert property (@(posedge clk) disable iff (rst)
        taken |-> (redirect_npc == redirect_pc + XLEN'(INST_BYTES)));

    // R4: delay-slot flag tracks the request
    assert_bd_track_R4: assert property (@(posedge clk) disable iff (rst)
        accept |=> (cause_bd == $past(exc_in_delay)));
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        exc_refill = 1'b0;
    logic [31:0] exc_pc = '0;
    logic        exc_in_delay = 1'b0;
    logic        sr_bev = 1'b0, sr_exl = 1'b0, sr_erl = 1'b0;
    logic        sr_ux = 1'b0, sr_sx = 1'b0, sr_kx = 1'b0;
    logic [1:0]  fault_region = '0;
    logic        taken, exl_set, cause_bd;
    logic [31:0] redirect_pc, redirect_npc, epc;
    logic [4:0]  cause_code;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        string       tag;
        logic        tk;
        logic [31:0] pc;
        logic [31:0] npc;
        logic        xs;
        logic [31:0] ep;
        logic [4:0]  cd;
        logic        bd;
    } exp_t;

    exp_t sb[$];

    // bench model of held state
    logic [31:0] m_pc = '0, m_npc = '0, m_epc = '0;
    logic [4:0]  m_cd = '0;
    logic        m_bd = 1'b0;

    always #4 clk = ~clk;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code),
        .exc_refill(exc_refill), .exc_pc(exc_pc), .exc_in_delay(exc_in_delay),
        .sr_bev(sr_bev), .sr_exl(sr_exl), .sr_erl(sr_erl),
        .sr_ux(sr_ux), .sr_sx(sr_sx), .sr_kx(sr_kx), .fault_region(fault_region),
        .taken(taken), .redirect_pc(redirect_pc), .redirect_npc(redirect_npc),
        .exl_set(exl_set), .epc(epc), .cause_code(cause_code), .cause_bd(cause_bd)
    );

    task automatic chk(string tag, string fld, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
        end
    endtask

    // driver: applies one request and pushes the expected result
    task automatic drive(string tag, logic [4:0] code, logic refill, logic [31:0] pc,
                         logic dly, logic bev, logic exl, logic erl,
                         logic ux, logic sx, logic kx, logic [1:0] rgn);
        exp_t e;
        logic [31:0] base, vec;
        logic xr;
        @(negedge clk);
        exc_req = 1'b1; exc_code = code; exc_refill = refill; exc_pc = pc;
        exc_in_delay = dly; sr_bev = bev; sr_exl = exl; sr_erl = erl;
        sr_ux = ux; sr_sx = sx; sr_kx = kx; fault_region = rgn;
        base = bev ? 32'hBFC0_0200 : 32'h8000_0000;
        xr = (rgn == 2'd0 && ux) || (rgn == 2'd1 && sx) || (rgn == 2'd3 && kx);
        vec = !refill ? base + 32'h180 : (xr ? base + 32'h80 : base);
        e.tag = tag;
        if (erl) begin
            e.tk = 1'b0; e.xs = 1'b0;
        end else begin
            e.tk = 1'b1; e.xs = !exl;
            m_cd = code; m_bd = dly;
            if (!exl) m_epc = dly ? pc - 32'd4 : pc;
            m_pc = vec; m_npc = vec + 32'd4;
        end
        e.pc = m_pc; e.npc = m_npc; e.ep = m_epc; e.cd = m_cd; e.bd = m_bd;
        sb.push_back(e);
        @(negedge clk);
        exc_req = 1'b0;
    endtask

    // monitor: compares right after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst) begin
                if (sb.size() > 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(e.tag, "taken",   32'(taken),      32'(e.tk));
                    chk(e.tag, "pc",      redirect_pc,     e.pc);
                    chk(e.tag, "npc",     redirect_npc,    e.npc);
                    chk(e.tag, "exl_set", 32'(exl_set),    32'(e.xs));
                    chk(e.tag, "epc",     epc,             e.ep);
                    chk(e.tag, "code",    32'(cause_code), 32'(e.cd));
                    chk(e.tag, "bd",      32'(cause_bd),   32'(e.bd));
                end else if (taken || exl_set) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R3 idle taken=%b exl_set=%b expected 0 0", taken, exl_set);
                end
            end
        end
    end

    initial begin
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "taken", 32'(taken), 0);
        chk("R1", "pc", redirect_pc, 0);
        chk("R1", "npc", redirect_npc, 0);
        chk("R1", "epc", epc, 0);
        chk("R1", "code/bd/xs", {cause_code, cause_bd, exl_set}, 0);

        // R3 R5 R6: first-level general exception, BEV 0
        drive("R3_R6", 5'd4, 0, 32'h0040_1000, 0, 0, 0, 0, 0, 0, 0, 2'd0);
        // R4: delay slot
        drive("R4", 5'd2, 0, 32'h0040_2008, 1, 0, 0, 0, 0, 0, 0, 2'd0);
        // R5: nested in delay slot, epc kept, cause updated
        drive("R5", 5'd9, 0, 32'h0050_0010, 1, 0, 1, 0, 0, 0, 0, 2'd0);
        // R5: nested not in delay slot
        drive("R5", 5'd3, 1, 32'h0050_0020, 0, 1, 1, 0, 0, 0, 0, 2'd0);
        // R2: error level blocks everything
        drive("R2", 5'd12, 0, 32'h1234_5678, 1, 1, 0, 1, 1, 1, 1, 2'd0);
        // R7: refill, user region, UX off
        drive("R7", 5'd2, 1, 32'h0000_4000, 0, 0, 0, 0, 0, 1, 1, 2'd0);
        // R8: user region, UX on
        drive("R8", 5'd3, 1, 32'h0000_4100, 0, 0, 0, 0, 1, 0, 0, 2'd0);
        // R8: supervisor region, SX on
        drive("R8", 5'd2, 1, 32'h4000_0000, 0, 0, 0, 0, 0, 1, 0, 2'd1);
        // R8: kernel region, KX on, BEV 1
        drive("R8", 5'd3, 1, 32'hC000_0000, 1, 1, 0, 0, 0, 0, 1, 2'd3);
        // R8: region 2 never extended
        drive("R8", 5'd2, 1, 32'h8000_1000, 0, 0, 0, 0, 1, 1, 1, 2'd2);
        // R7: kernel region with only UX/SX set
        drive("R7", 5'd2, 1, 32'hC000_1000, 0, 1, 0, 0, 1, 1, 0, 2'd3);
        // R6 R9: general exception, BEV 1
        drive("R6_R9", 5'd31, 0, 32'hFFFF_FFFC, 0, 1, 0, 0, 0, 0, 0, 2'd0);
        // R2 again after state is non-zero
        drive("R2", 5'd1, 1, 32'h0000_0000, 0, 0, 1, 1, 0, 0, 0, 2'd0);

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R3 pending results actual %0d expected 0", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule